// File: doc/BRIEF.md
# Scaled Four-Stage CIC Decimator

This block lowers the sample rate of one real component (I or Q) of a full-rate mixer output by an integer factor N. A new 22-bit signed sample is taken on every clock. The sample first passes a programmable left-shift stage. It then goes through four cascaded integrators running at the clock rate, and four comb sections that update once every N clocks. For a complex signal, two copies of the block run side by side.

The CIC sections have a gain of N^4. The left-shift stage and the final selection of the top 22 bits offset that gain. With the shift amount S, the net gain is N^4 · 2^(S−44). The datapath is 66 bits wide, and with S = 0 the input sits sign-extended in its lowest bits. The decimation factor is programmed as N − 1. The passband is a sin(x)/x lowpass whose first null lies at Fs/N. Each decimated result comes out with a one-clock valid strobe.

Top module: `cic4_decimator`

## Requirements
- R1: With a constant input x held long enough, every decimated output equals floor(x · N^4 · 2^S / 2^44), provided x · N^4 · 2^S fits in 66-bit signed range. Negative values round toward minus infinity.
- R2: With `dec_cfg` = N − 1 and N in 8..2048, `dout_vld` pulses exactly once every N clocks.
- R3: A `dec_cfg` value below 7 behaves as 7 (N = 8). A value above 2047 behaves as 2047 (N = 2048).
- R4: The decimation counter reads `dec_cfg` only when it leaves reset and when it rolls over. If the value changes just after a valid strobe, the next interval still uses the old N, and the interval after that uses the new N.
- R5: `dout_vld` is high for a single clock. `dout` holds its value in every cycle where `dout_vld` is low.
- R6: A `scale_cfg` value above 40 gives the same gain as 40.
- R7: While `rst_n` is low, `dout` is 0 and `dout_vld` is 0.
- R8: The output is the top 22 bits of the 66-bit comb result. Integrators wrap modulo 2^66 without affecting a result that fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one input sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 22 | Signed two's-complement input sample |
| dec_cfg | input | 12 | Decimation setting, N − 1, clamped to 7..2047 |
| scale_cfg | input | 6 | Left-shift amount S, clamped to 0..40 |
| dout | output | 22 | Signed decimated output sample |
| dout_vld | output | 1 | One-clock strobe marking a new `dout` |

## Verification
The integrator states are never visible directly. A corrupted integrator or comb delay shows up as a DC output that misses N^4 · 2^(S−44). Such an error is seen within a few decimated samples, because a sum that is wrong by even one LSB in the upper bits never settles back. A miscounting decimation counter shows up as a valid spacing other than N, which is visible at the very next strobe. Sweeping several N and S pairs with both signs of input exposes a shift, clamp or truncation fault as a fixed wrong value.

// File: rtl/cic4_pkg.sv
package cic4_pkg;
  localparam int unsigned CIC_IN_W      = 22;
  localparam int unsigned CIC_ACC_W     = 66;
  localparam int unsigned CIC_OUT_W     = 22;
  localparam int unsigned CIC_DEC_IN_W  = 12;
  localparam int unsigned CIC_DEC_W     = 11;
  localparam int unsigned CIC_SCALE_W   = 6;
  localparam int unsigned CIC_MIN_DEC   = 7;
  localparam int unsigned CIC_MAX_DEC   = 2047;
  localparam int unsigned CIC_MAX_SCALE = 40;
  localparam int unsigned CIC_STAGES    = 4;
endpackage

// File: rtl/cic4_shift_up.sv
module cic4_shift_up #(
  parameter int unsigned IN_W      = 22,
  parameter int unsigned ACC_W     = 66,
  parameter int unsigned SCALE_W   = 6,
  parameter int unsigned MAX_SCALE = 40
) (
  input  logic signed [IN_W-1:0]    din,
  input  logic        [SCALE_W-1:0] scale_cfg,
  output logic signed [ACC_W-1:0]   dout
);
  localparam int unsigned EXT_W = ACC_W - IN_W;

  logic [SCALE_W-1:0]      scale_eff;
  logic signed [ACC_W-1:0] ext;

  // clamp the shift amount so the product stays in the path
  always_comb begin
    if (scale_cfg > SCALE_W'(MAX_SCALE)) scale_eff = SCALE_W'(MAX_SCALE);
    else                                 scale_eff = scale_cfg;
  end

  always_comb begin
    ext  = {{EXT_W{din[IN_W-1]}}, din};
    dout = ext <<< scale_eff;
  end
endmodule

// File: rtl/cic4_dec_ctrl.sv
module cic4_dec_ctrl #(
  parameter int unsigned DEC_IN_W = 12,
  parameter int unsigned DEC_W    = 11,
  parameter int unsigned MIN_DEC  = 7,
  parameter int unsigned MAX_DEC  = 2047
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEC_IN_W-1:0] dec_cfg,
  output logic                strobe
);
  logic [DEC_W-1:0] dec_eff;
  logic [DEC_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    if (dec_cfg < DEC_IN_W'(MIN_DEC))      dec_eff = DEC_W'(MIN_DEC);
    else if (dec_cfg > DEC_IN_W'(MAX_DEC)) dec_eff = DEC_W'(MAX_DEC);
    else                                   dec_eff = DEC_W'(dec_cfg);
  end

  // first cycle out of reset loads the count; afterwards reload at zero
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    strobe  = 1'b0;
    if (!armed_q) begin
      armed_d = 1'b1;
      cnt_d   = dec_eff;
    end else if (cnt_q == '0) begin
      strobe = 1'b1;
      cnt_d  = dec_eff;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/cic4_integ_stage.sv
module cic4_integ_stage #(
  parameter int unsigned ACC_W = 66
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] acc_q, acc_d;

  // modulo-2^ACC_W accumulation; wrap is harmless for in-range results
  always_comb acc_d = acc_q + din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign dout = acc_q;
endmodule

// File: rtl/cic4_comb_stage.sv
module cic4_comb_stage #(
  parameter int unsigned ACC_W = 66
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] dly_q, dly_d;

  always_comb begin
    dly_d = dly_q;
    if (en) dly_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  assign dout = din - dly_q;
endmodule

// File: rtl/cic4_decimator.sv
module cic4_decimator
  import cic4_pkg::*;
#(
  parameter int unsigned IN_W      = CIC_IN_W,
  parameter int unsigned ACC_W     = CIC_ACC_W,
  parameter int unsigned OUT_W     = CIC_OUT_W,
  parameter int unsigned DEC_IN_W  = CIC_DEC_IN_W,
  parameter int unsigned DEC_W     = CIC_DEC_W,
  parameter int unsigned SCALE_W   = CIC_SCALE_W,
  parameter int unsigned MIN_DEC   = CIC_MIN_DEC,
  parameter int unsigned MAX_DEC   = CIC_MAX_DEC,
  parameter int unsigned MAX_SCALE = CIC_MAX_SCALE,
  parameter int unsigned STAGES    = CIC_STAGES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [IN_W-1:0]     din,
  input  logic        [DEC_IN_W-1:0] dec_cfg,
  input  logic        [SCALE_W-1:0]  scale_cfg,
  output logic signed [OUT_W-1:0]    dout,
  output logic                       dout_vld
);
  localparam int unsigned DROP_W = ACC_W - OUT_W;

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       strobe;

  logic signed [ACC_W-1:0] integ_link [STAGES+1];
  logic signed [ACC_W-1:0] comb_link  [STAGES+1];

  logic signed [OUT_W-1:0] dout_q, dout_d;
  logic                    vld_q, vld_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cic4_shift_up #(
    .IN_W(IN_W), .ACC_W(ACC_W), .SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)
  ) shift_i (
    .din(din), .scale_cfg(scale_cfg), .dout(integ_link[0])
  );

  cic4_dec_ctrl #(
    .DEC_IN_W(DEC_IN_W), .DEC_W(DEC_W), .MIN_DEC(MIN_DEC), .MAX_DEC(MAX_DEC)
  ) ctrl_i (
    .clk(clk), .rst_n(core_rst_n), .dec_cfg(dec_cfg), .strobe(strobe)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_integ
    cic4_integ_stage #(.ACC_W(ACC_W)) stage_i (
      .clk(clk), .rst_n(core_rst_n),
      .din(integ_link[g]), .dout(integ_link[g+1])
    );
  end

  assign comb_link[0] = integ_link[STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    cic4_comb_stage #(.ACC_W(ACC_W)) stage_i (
      .clk(clk), .rst_n(core_rst_n), .en(strobe),
      .din(comb_link[g]), .dout(comb_link[g+1])
    );
  end

  // keep the top OUT_W bits: arithmetic shift then narrow
  always_comb begin
    dout_d = dout_q;
    vld_d  = strobe;
    if (strobe) dout_d = OUT_W'(comb_link[STAGES] >>> DROP_W);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      vld_q  <= vld_d;
    end
  end

  assign dout     = dout_q;
  assign dout_vld = vld_q;
endmodule

// File: rtl/cic4_decimator_chk.sv
module cic4_decimator_chk #(
  parameter int unsigned OUT_W = 22,
  parameter int unsigned MIN_N = 8,
  parameter int unsigned MAX_N = 2048
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic signed [OUT_W-1:0] dout,
  input logic                    dout_vld
);
  localparam int unsigned GAP_W = $clog2(MAX_N + 2) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (dout_vld) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else if (gap_q != {GAP_W{1'b1}}) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R2 / R3: spacing between strobes stays within the clamped range
  a_r2_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && seen_q) |-> (gap_q >= GAP_W'(MIN_N)));

  a_r3_gap_max: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (gap_q <= GAP_W'(MAX_N)));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |=> !dout_vld);

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> $stable(dout));
endmodule

bind cic4_decimator cic4_decimator_chk #(
  .OUT_W(OUT_W), .MIN_N(MIN_DEC + 1), .MAX_N(MAX_DEC + 1)
) chk_i (
  .clk(clk), .rst_n(rst_n), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/cic4_decimator_tb_top.sv
module cic4_decimator_tb_top;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [21:0] din = '0;
  logic [11:0]        dec_cfg = 12'd7;
  logic [5:0]         scale_cfg = '0;
  logic signed [21:0] dout;
  logic               dout_vld;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cic4_decimator dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .dec_cfg(dec_cfg),
    .scale_cfg(scale_cfg), .dout(dout), .dout_vld(dout_vld)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint dc_expect(input longint n, input int s, input longint x);
    logic signed [127:0] p;
    p = 128'(x);
    p = p * 128'(n * n * n * n);
    p = p <<< s;
    p = p >>> 44;
    return longint'(p);
  endfunction

  task automatic do_reset(input int dec, input int sc, input longint x);
    rst_n     = 1'b0;
    dec_cfg   = 12'(dec);
    scale_cfg = 6'(sc);
    din       = 22'(x);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_vld(output int at);
    do begin
      @(posedge clk);
      #1;
    end while (!dout_vld);
    at = cyc;
  endtask

  // reset, settle for eight strobes, then check value, spacing and hold
  task automatic run_dc(input int dec, input int n_eff, input int s_cfg,
                        input int s_eff, input longint x, input string req);
    int t0, t1;
    longint exp_v;
    logic signed [21:0] held;
    do_reset(dec, s_cfg, x);
    for (int k = 0; k < 8; k++) wait_vld(t0);
    exp_v = dc_expect(n_eff, s_eff, x);
    wait_vld(t1);
    check(dout == 22'(exp_v), req, longint'(dout), exp_v);
    check((t1 - t0) == n_eff, "R2 interval", longint'(t1 - t0), longint'(n_eff));
    held = dout;
    @(posedge clk); #1;
    check(!dout_vld && dout == held, "R5 hold", longint'(dout), longint'(held));
    wait_vld(t0);
    check(dout == 22'(exp_v), req, longint'(dout), exp_v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", longint'(cyc), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ta, tb, tc;
    // R7: outputs held at zero in reset
    rst_n = 1'b0;
    din   = 22'sd1000;
    repeat (4) @(posedge clk);
    #1;
    check(dout == '0, "R7 dout", longint'(dout), 0);
    check(!dout_vld, "R7 vld", longint'(dout_vld), 0);

    // R1: several N / S pairs, both signs
    run_dc(7,    8,    32, 32, 12345,    "R1 N8 S32 pos");
    run_dc(7,    8,    32, 32, -2000000, "R1 N8 S32 neg");
    run_dc(15,   16,   28, 28, 777,      "R1 N16 S28");
    run_dc(9,    10,   30, 30, 1000,     "R1 N10 S30");
    run_dc(99,   100,  16, 16, 50000,    "R1 N100 S16");
    run_dc(12,   13,   20, 20, -31000,   "R1 N13 S20");
    // R8: truncation toward minus infinity, wrap through long runs
    run_dc(9,    10,   30, 30, -1,       "R8 floor neg");
    run_dc(7,    8,    0,  0,  2097151,  "R8 top bits small");
    run_dc(2047, 2048, 0,  0,  1048575,  "R8 N2048 unity");
    // R6: shift above 40 behaves as 40
    run_dc(7,    8,    63, 40, 1,        "R6 scale clamp");
    // R3: decimation setting clamped at both ends
    run_dc(3,    8,    32, 32, 5,        "R3 low clamp");
    run_dc(4000, 2048, 0,  0,  -4096,    "R3 high clamp");

    // R4: a change right after a strobe shows up one interval later
    do_reset(7, 32, 100);
    wait_vld(ta);
    wait_vld(ta);
    dec_cfg = 12'd19;
    wait_vld(tb);
    wait_vld(tc);
    check((tb - ta) == 8,  "R4 old period", longint'(tb - ta), 8);
    check((tc - tb) == 20, "R4 new period", longint'(tc - tb), 20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule